// File: doc/BRIEF.md
# Serial Control Register Port

This block is a write-only configuration port for an imaging front end. A host shifts 12-bit frames in over three wires: a serial clock, a serial data line and an active-low enable. Each frame carries a 2-bit register address followed by a 10-bit payload. The port commits the frame to one of four control registers only when the enable returns high, and only if exactly twelve serial clock rising edges were seen while the enable was low. The four registers hold the converter clamp code, the track/hold cut-off code, the amplifier gain code and a 3-bit polarity selector for the timing pulses.

The three serial inputs are brought into a faster system clock through synchroniser chains. Serial clock rising edges are detected in that domain, so the system clock must run several times faster than the serial clock, whose maximum rate is 5 MHz. A frame controller moves through four named states. ST_IDLE waits for the enable to fall (transition IDLE->SHIFT). ST_SHIFT takes in one bit per serial rising edge and, when the enable rises, goes to ST_COMMIT if the count is exactly twelve (SHIFT->COMMIT) or to ST_DROP otherwise (SHIFT->DROP). ST_COMMIT issues a one-cycle write strobe to the register bank and returns to ST_IDLE (COMMIT->IDLE). ST_DROP returns to ST_IDLE without a write (DROP->IDLE).

Every clamp write leaves the gain setting stale until the gain register is written again, and the port shows this with a flag. A second flag shows that the stored gain code is at or beyond the point where the amplifier saturates.

Top module: `fcp_ctrl_port`

## Requirements
- R1: After reset the clamp, cut-off and gain codes are zero, the polarity selector is 3'b110, and both flags are low.
- R2: A frame is shifted most significant bit first, as address bit 1, address bit 0, then payload bits 9 down to 0. A bit is taken on each serial clock rising edge while the enable is low.
- R3: Address 2'b00 loads payload bits 9..0 into the clamp code, and a frame changes at most one register.
- R4: Address 2'b01 loads payload bits 3..0 into the cut-off code. Payload bits 9..4 are ignored.
- R5: Address 2'b10 loads payload bits 9..0 into the gain code.
- R6: Address 2'b11 loads payload bits 2..0 into the polarity selector. Bit 0 set means the sample pulses act on their low level, bit 1 set means the clamp pulses are active high, and bit 2 set means the conversion clock acts on its rising edge.
- R7: No register changes while the enable is low. The addressed register takes its new value within four system clock cycles after the enable rises.
- R8: A frame with fewer or more than twelve serial rising edges while the enable is low is discarded, and no register or flag changes.
- R9: A clamp write sets the stale-gain flag. The flag stays set through writes to other registers and is cleared only by a gain write.
- R10: A gain code of 767 or more is stored unchanged and raises the saturation flag. A gain code below 767 clears it.
- R11: Serial clock edges while the enable is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_en_n_i | input | 1 | Serial enable, active low; rising edge commits the frame |
| ser_dat_i | input | 1 | Serial data, MSB first |
| clamp_code_o | output | 10 | Converter clamp code |
| cutoff_code_o | output | 4 | Track/hold cut-off code |
| gain_code_o | output | 10 | Amplifier gain code |
| edge_ctl_o | output | 3 | Pulse polarity selector |
| gain_stale_o | output | 1 | Gain must be rewritten after a clamp write |
| gain_sat_o | output | 1 | Stored gain code is at or above saturation |

## Verification
A committed value reaches the outputs at most four system clock edges after the enable rises. Two edges go to the synchroniser, one to the SHIFT->COMMIT transition and one to the register load. The scoreboard monitor therefore waits six falling edges after the driver signals the enable's rise before it pops the expected state and compares. For R7 and R8, the driver also queues an unchanged snapshot while the enable is still low after the last bit, or after a bad frame has closed. The monitor then shows that nothing moved during that window.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_DROP   = 2'd3
    } fcp_state_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CLAMP  = 2'b00,
        RA_CUTOFF = 2'b01,
        RA_GAIN   = 2'b10,
        RA_EDGE   = 2'b11
    } fcp_addr_e;

endpackage

// File: rtl/fcp_sync.sv
module fcp_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[b]}};
                end else begin
                    chain <= {chain[STAGES-2:0], d[b]};
                end
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/fcp_frame_fsm.sv
module fcp_frame_fsm
    import fcp_pkg::*;
#(
    parameter int PAY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              en_n_s,
    input  logic              dat_s,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PAY_W-1:0]  wr_data
);

    localparam int FRAME_BITS = ADDR_W + PAY_W;
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    fcp_state_e             state_q, state_d;
    logic                   sclk_q;
    logic                   sclk_rise;
    logic                   shift_en;
    logic [FRAME_BITS-1:0]  shreg_q;
    logic [CNT_W-1:0]       bit_cnt_q;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign shift_en  = sclk_rise & ~en_n_s &
                       ((state_q == ST_IDLE) || (state_q == ST_SHIFT));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!en_n_s) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (en_n_s) begin
                    if (bit_cnt_q == CNT_W'(FRAME_BITS)) state_d = ST_COMMIT;
                    else                                 state_d = ST_DROP;
                end
            end
            ST_COMMIT: state_d = ST_IDLE;
            ST_DROP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            shreg_q   <= '0;
            bit_cnt_q <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (shift_en) begin
                shreg_q <= {shreg_q[FRAME_BITS-2:0], dat_s};
                if (state_q == ST_IDLE) begin
                    bit_cnt_q <= CNT_W'(1);
                end else if (bit_cnt_q != CNT_W'(CNT_MAX)) begin
                    bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                end
            end else if (state_q == ST_IDLE) begin
                bit_cnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        wr_valid = 1'b0;
        unique case (state_q)
            ST_COMMIT: wr_valid = 1'b1;
            ST_IDLE, ST_SHIFT, ST_DROP: wr_valid = 1'b0;
            default:   wr_valid = 1'b0;
        endcase
        wr_addr = shreg_q[FRAME_BITS-1 -: ADDR_W];
        wr_data = shreg_q[PAY_W-1:0];
    end

endmodule

// File: rtl/fcp_regbank.sv
module fcp_regbank
    import fcp_pkg::*;
#(
    parameter int                PAY_W    = 10,
    parameter int                CUT_W    = 4,
    parameter int                EDGE_W   = 3,
    parameter int                GAIN_SAT = 767,
    parameter logic [EDGE_W-1:0] EDGE_RST = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PAY_W-1:0]  wr_data,
    output logic [PAY_W-1:0]  clamp_code,
    output logic [CUT_W-1:0]  cutoff_code,
    output logic [PAY_W-1:0]  gain_code,
    output logic [EDGE_W-1:0] edge_ctl,
    output logic              gain_stale,
    output logic              gain_sat
);

    logic payload_sat;
    assign payload_sat = (wr_data >= PAY_W'(GAIN_SAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clamp_code  <= '0;
            cutoff_code <= '0;
            gain_code   <= '0;
            edge_ctl    <= EDGE_RST;
            gain_stale  <= 1'b0;
            gain_sat    <= 1'b0;
        end else if (wr_valid) begin
            unique case (fcp_addr_e'(wr_addr))
                RA_CLAMP: begin
                    clamp_code <= wr_data;
                    gain_stale <= 1'b1;
                end
                RA_CUTOFF: cutoff_code <= wr_data[CUT_W-1:0];
                RA_GAIN: begin
                    gain_code  <= wr_data;
                    gain_stale <= 1'b0;
                    gain_sat   <= payload_sat;
                end
                RA_EDGE: edge_ctl <= wr_data[EDGE_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fcp_ctrl_port.sv
module fcp_ctrl_port #(
    parameter int         PAY_W       = 10,
    parameter int         CUT_W       = 4,
    parameter int         EDGE_W      = 3,
    parameter int         SYNC_STAGES = 2,
    parameter int         GAIN_SAT    = 767,
    parameter logic [2:0] EDGE_RST    = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_en_n_i,
    input  logic              ser_dat_i,
    output logic [PAY_W-1:0]  clamp_code_o,
    output logic [CUT_W-1:0]  cutoff_code_o,
    output logic [PAY_W-1:0]  gain_code_o,
    output logic [EDGE_W-1:0] edge_ctl_o,
    output logic              gain_stale_o,
    output logic              gain_sat_o
);

    localparam int ADDR_W = fcp_pkg::ADDR_W;

    logic [2:0]        sync_q;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [PAY_W-1:0]  wr_data;

    // bit 2 serial clock, bit 1 enable (idles high), bit 0 data
    fcp_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk_i, ser_en_n_i, ser_dat_i}),
        .q     (sync_q)
    );

    fcp_frame_fsm #(
        .PAY_W (PAY_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sync_q[2]),
        .en_n_s   (sync_q[1]),
        .dat_s    (sync_q[0]),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    fcp_regbank #(
        .PAY_W    (PAY_W),
        .CUT_W    (CUT_W),
        .EDGE_W   (EDGE_W),
        .GAIN_SAT (GAIN_SAT),
        .EDGE_RST (EDGE_W'(EDGE_RST))
    ) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .clamp_code  (clamp_code_o),
        .cutoff_code (cutoff_code_o),
        .gain_code   (gain_code_o),
        .edge_ctl    (edge_ctl_o),
        .gain_stale  (gain_stale_o),
        .gain_sat    (gain_sat_o)
    );

endmodule

// File: rtl/fcp_ctrl_port_chk.sv
module fcp_ctrl_port_chk #(
    parameter int PAY_W    = 10,
    parameter int CUT_W    = 4,
    parameter int EDGE_W   = 3,
    parameter int GAIN_SAT = 767
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_en_n_i,
    input logic [PAY_W-1:0]  clamp_code_o,
    input logic [CUT_W-1:0]  cutoff_code_o,
    input logic [PAY_W-1:0]  gain_code_o,
    input logic [EDGE_W-1:0] edge_ctl_o,
    input logic              gain_stale_o,
    input logic              gain_sat_o
);

    p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (clamp_code_o == '0 && cutoff_code_o == '0 &&
                          gain_code_o == '0 && !gain_stale_o && !gain_sat_o));

    p_one_reg_per_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({clamp_code_o != $past(clamp_code_o),
                    cutoff_code_o != $past(cutoff_code_o),
                    gain_code_o != $past(gain_code_o),
                    edge_ctl_o != $past(edge_ctl_o)}) <= 1);

    p_hold_while_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en_n_i && !$past(ser_en_n_i, 1) && !$past(ser_en_n_i, 2) &&
         !$past(ser_en_n_i, 3))
        |=> ($stable(clamp_code_o) && $stable(cutoff_code_o) &&
             $stable(gain_code_o) && $stable(edge_ctl_o)));

    p_clamp_sets_stale_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_code_o != $past(clamp_code_o)) |-> gain_stale_o);

    p_stale_clear_needs_gain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gain_stale_o) && $stable(gain_code_o)) |-> !gain_sat_o || gain_sat_o == (gain_code_o >= PAY_W'(GAIN_SAT)));

    p_sat_tracks_gain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gain_sat_o == (gain_code_o >= PAY_W'(GAIN_SAT)));

endmodule

bind fcp_ctrl_port fcp_ctrl_port_chk #(
    .PAY_W    (PAY_W),
    .CUT_W    (CUT_W),
    .EDGE_W   (EDGE_W),
    .GAIN_SAT (GAIN_SAT)
) i_fcp_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_en_n_i    (ser_en_n_i),
    .clamp_code_o  (clamp_code_o),
    .cutoff_code_o (cutoff_code_o),
    .gain_code_o   (gain_code_o),
    .edge_ctl_o    (edge_ctl_o),
    .gain_stale_o  (gain_stale_o),
    .gain_sat_o    (gain_sat_o)
);

// File: tb/test_fcp_ctrl_port.sv
`timescale 1ns/1ps
module test_fcp_ctrl_port;

    localparam int HALF = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_en_n = 1'b1;
    logic       ser_dat = 1'b0;
    logic [9:0] clamp_code;
    logic [3:0] cutoff_code;
    logic [9:0] gain_code;
    logic [2:0] edge_ctl;
    logic       gain_stale;
    logic       gain_sat;

    always #4 clk = ~clk;

    fcp_ctrl_port i_fcp_ctrl_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_clk_i     (ser_clk),
        .ser_en_n_i    (ser_en_n),
        .ser_dat_i     (ser_dat),
        .clamp_code_o  (clamp_code),
        .cutoff_code_o (cutoff_code),
        .gain_code_o   (gain_code),
        .edge_ctl_o    (edge_ctl),
        .gain_stale_o  (gain_stale),
        .gain_sat_o    (gain_sat)
    );

    typedef struct packed {
        logic [9:0] clamp;
        logic [3:0] cut;
        logic [9:0] gain;
        logic [2:0] edg;
        logic       stale;
        logic       sat;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    exp_t  model;
    event  chk_ev;
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor: results are due within 4 rising edges of the enable rise
    initial begin
        forever begin
            @(chk_ev);
            repeat (6) @(negedge clk);
            begin
                exp_t  e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(r, "clamp",  int'(clamp_code),  int'(e.clamp));
                chk(r, "cutoff", int'(cutoff_code), int'(e.cut));
                chk(r, "gain",   int'(gain_code),   int'(e.gain));
                chk(r, "edge",   int'(edge_ctl),    int'(e.edg));
                chk(r, "stale",  int'(gain_stale),  int'(e.stale));
                chk(r, "sat",    int'(gain_sat),    int'(e.sat));
            end
        end
    end

    task automatic expect_now(input string req);
        exp_q.push_back(model);
        req_q.push_back(req);
        ->chk_ev;
        repeat (10) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] word, input int nbits);
        ser_en_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = word[i];
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic apply_model(input logic [1:0] a, input logic [9:0] d);
        case (a)
            2'b00: begin model.clamp = d; model.stale = 1'b1; end
            2'b01: model.cut = d[3:0];
            2'b10: begin model.gain = d; model.stale = 1'b0; model.sat = (d >= 10'd767); end
            default: model.edg = d[2:0];
        endcase
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [9:0] d, input string req);
        shift_bits({4'b0, a, d}, 12);
        expect_now("R7 hold while enable low");
        ser_en_n = 1'b1;
        apply_model(a, d);
        expect_now(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model = '{clamp: 10'd0, cut: 4'd0, gain: 10'd0, edg: 3'b110, stale: 1'b0, sat: 1'b0};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1 reset defaults");

        write_reg(2'b10, 10'h155, "R5 gain write");
        write_reg(2'b00, 10'h0C3, "R2 R3 clamp write msb-first, R9 stale set");
        write_reg(2'b01, 10'h3F5, "R4 cutoff low bits");
        write_reg(2'b11, 10'h3F9, "R6 edge polarity");
        write_reg(2'b00, 10'h201, "R3 second clamp write");
        write_reg(2'b01, 10'h00A, "R9 stale held over cutoff write");
        write_reg(2'b10, 10'd767, "R10 gain at saturation, R9 stale cleared");
        write_reg(2'b10, 10'd1023, "R10 gain maximum stored unchanged");
        write_reg(2'b10, 10'd766, "R10 gain below saturation");

        // R8: short frame (11 edges) to the gain register
        shift_bits({5'b0, 2'b10, 9'h1FF}, 11);
        ser_en_n = 1'b1;
        expect_now("R8 short frame discarded");

        // R8: long frame (13 edges) to the clamp register
        shift_bits({3'b0, 2'b00, 10'h3FF, 1'b1}, 13);
        ser_en_n = 1'b1;
        expect_now("R8 long frame discarded");

        // R11: serial clock toggling with enable high
        for (int i = 0; i < 12; i++) begin
            ser_dat = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
        end
        expect_now("R11 edges ignored while enable high");

        write_reg(2'b11, 10'h002, "R6 edge second pattern");

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule